// File: doc/BRIEF.md
# Configurable Microcontroller GPIO Port

This block is one parallel I/O port that sits on a processor's register bus. It holds four per-pin registers: mode, direction, drive and data. The processor writes them with single-cycle bus writes and reads them back combinationally. A fifth read-only offset returns the state of the external pins after a two-flop synchronizer. Bit n of every register belongs to pin n.

For each pin the block works out three things:
- **Driven value.** The mode bit picks between the processor's data latch and the matching bit of an address bus.
- **Enable.** The direction bit and an external output-enable request are OR-ed together.
- **Driver style.** The drive bit means one of two things, and a parameter mask decides which for each pin. On pins without slew control it selects open-drain drive, where the pin only ever pulls low. On slew-capable pins it selects a fast edge rate.

Parameters set:
- the number of implemented pins, so a narrow two-pin port keeps only its low bits;
- whether the mode register exists at all.

Top module: `gpio_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, and `pin_oe` and `pin_fast` are all zero.
- R2: A bus write at offset 0 (mode), 1 (direction), 2 (drive) or 3 (data latch) takes effect at the clock edge. A read at the same offset then returns the written value, masked to implemented bits.
- R3: Reads at offsets 5, 6 and 7 return 0. When `ADDR_CAPABLE` is 0, the mode register reads 0 and every pin uses the data latch.
- R4: With mode bit 0 a pin's value is its data latch bit; with mode bit 1 it is the matching `addr_bits` bit.
- R5: On a push-pull pin, `pin_oe` is the OR of the direction bit and the `ext_oe` bit, and `pin_out` equals the pin value.
- R6: On an open-drain pin (drive bit 1, slew-mask bit 0), `pin_out` is 0 and `pin_oe` is set only when the pin is enabled and its value is 0.
- R7: `pin_fast` equals the drive bit on pins whose `SLEW_MASK` bit is 1, and is 0 on the others.
- R8: A read at offset 4 returns `pin_in` as captured two clock edges earlier, regardless of direction.
- R9: Pins at or above `ACTIVE_PINS` read 0 in every register, never drive `pin_oe`, `pin_out` or `pin_fast`, and read 0 at offset 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Read data, zero when not selected |
| addr_bits | input | PIN_W | Address bits for address-out mode |
| ext_oe | input | PIN_W | External per-pin output-enable request |
| pin_in | input | PIN_W | Asynchronous pin levels |
| pin_oe | output | PIN_W | Per-pin tri-state enable |
| pin_out | output | PIN_W | Per-pin output value |
| pin_fast | output | PIN_W | Per-pin fast-slew select |

## Verification
The assertions assume a few things about the block's inputs:
- `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are known and stable around each rising edge.
- `ext_oe` and `addr_bits` are steady before the output checks are sampled.
- `pin_in` changes only between edges, so the synchronizer latency check reads a clean value.

The stimulus respects all of this by changing every input at the falling edge. It samples outputs a short time after that edge, never at the rising edge. The direction, mode and drive registers are each swept through all 256 values, with external enables and data patterns derived from the sweep index.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
   localparam int OFS_W = 3;
   typedef enum logic [OFS_W-1:0] {
      REG_MODE = 3'd0,
      REG_DIR  = 3'd1,
      REG_DRV  = 3'd2,
      REG_DATA = 3'd3,
      REG_PINS = 3'd4
   } reg_ofs_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int PIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] pin_in,
   output logic [PIN_W-1:0] sync_q
);
   logic [PIN_W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= pin_in;
         sync_q <= meta_q;
      end
   end

   AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n, 2) |-> sync_q == $past(pin_in, 2)) else $error("sync latency"); // R8
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_cfg_pkg::*;
#(
   parameter int               PIN_W        = 8,
   parameter logic [PIN_W-1:0] ACT_MASK     = '1,
   parameter bit               ADDR_CAPABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [OFS_W-1:0] bus_addr,
   input  logic [PIN_W-1:0] bus_wdata,
   input  logic [PIN_W-1:0] pins_sync,
   output logic [PIN_W-1:0] bus_rdata,
   output logic [PIN_W-1:0] mode_q,
   output logic [PIN_W-1:0] dir_q,
   output logic [PIN_W-1:0] drv_q,
   output logic [PIN_W-1:0] data_q
);
   logic             wr_en;
   logic [PIN_W-1:0] wmask;

   assign wr_en = bus_sel & bus_wr;
   assign wmask = bus_wdata & ACT_MASK;

   generate
      if (ADDR_CAPABLE) begin : g_mode
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   mode_q <= '0;
            else if (wr_en && bus_addr == OFS_W'(REG_MODE)) mode_q <= wmask;
         end
      end else begin : g_no_mode
         assign mode_q = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         drv_q  <= '0;
         data_q <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            OFS_W'(REG_DIR):  dir_q  <= wmask;
            OFS_W'(REG_DRV):  drv_q  <= wmask;
            OFS_W'(REG_DATA): data_q <= wmask;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            OFS_W'(REG_MODE): bus_rdata = mode_q;
            OFS_W'(REG_DIR):  bus_rdata = dir_q;
            OFS_W'(REG_DRV):  bus_rdata = drv_q;
            OFS_W'(REG_DATA): bus_rdata = data_q;
            OFS_W'(REG_PINS): bus_rdata = pins_sync & ACT_MASK;
            default:          bus_rdata = '0;
         endcase
      end
   end

   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == OFS_W'(REG_DIR)) |=> dir_q == ($past(bus_wdata) & ACT_MASK))
      else $error("dir write"); // R2
   AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == OFS_W'(REG_DATA)) |=> data_q == ($past(bus_wdata) & ACT_MASK))
      else $error("data write"); // R2
   AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && bus_addr == OFS_W'(REG_DRV)) |=> $stable(drv_q))
      else $error("drv changed without write"); // R2
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
   parameter bit ACTIVE   = 1'b1,
   parameter bit SLEW_CAP = 1'b0
) (
   input  logic mode,
   input  logic dir,
   input  logic drv,
   input  logic data,
   input  logic addr,
   input  logic ext_oe,
   output logic oe,
   output logic out,
   output logic fast,
   output logic od
);
   logic value;
   logic enable;

   assign value  = mode ? addr : data;
   assign enable = ACTIVE & (dir | ext_oe);

   generate
      if (SLEW_CAP) begin : g_slew
         assign od   = 1'b0;
         assign fast = ACTIVE & drv;
      end else begin : g_odrain
         assign od   = ACTIVE & drv;
         assign fast = 1'b0;
      end
   endgenerate

   assign oe  = enable & (~od | ~value);
   assign out = ACTIVE & value & ~od;

   always_comb begin
      AST_OD_NO_HIGH: assert (!(od && out)) else $error("open-drain drove high"); // R6
   end
endmodule

// File: rtl/gpio_cfg_port.sv
module gpio_cfg_port
   import gpio_cfg_pkg::*;
#(
   parameter int               PIN_W        = 8,
   parameter int               ACTIVE_PINS  = 8,
   parameter bit               ADDR_CAPABLE = 1'b1,
   parameter logic [PIN_W-1:0] SLEW_MASK    = 8'hF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [PIN_W-1:0] bus_wdata,
   output logic [PIN_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0] addr_bits,
   input  logic [PIN_W-1:0] ext_oe,
   input  logic [PIN_W-1:0] pin_in,
   output logic [PIN_W-1:0] pin_oe,
   output logic [PIN_W-1:0] pin_out,
   output logic [PIN_W-1:0] pin_fast
);
   localparam logic [PIN_W-1:0] ACT_MASK = {PIN_W{1'b1}} >> (PIN_W - ACTIVE_PINS);

   initial begin
      AST_PARAM_PINS: assert (ACTIVE_PINS >= 1 && ACTIVE_PINS <= PIN_W)
         else $error("ACTIVE_PINS out of range"); // R9
      AST_PARAM_WIDTH: assert (PIN_W >= 1 && PIN_W <= 32)
         else $error("PIN_W out of range"); // R2
   end

   logic [PIN_W-1:0] mode_q, dir_q, drv_q, data_q, pins_sync, od_vec;

   gpio_in_sync #(.PIN_W(PIN_W)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .sync_q (pins_sync)
   );

   gpio_cfg_regs #(
      .PIN_W        (PIN_W),
      .ACT_MASK     (ACT_MASK),
      .ADDR_CAPABLE (ADDR_CAPABLE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pins_sync (pins_sync),
      .bus_rdata (bus_rdata),
      .mode_q    (mode_q),
      .dir_q     (dir_q),
      .drv_q     (drv_q),
      .data_q    (data_q)
   );

   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      gpio_pin_drv #(
         .ACTIVE   (i < ACTIVE_PINS),
         .SLEW_CAP (SLEW_MASK[i])
      ) u_drv (
         .mode   (mode_q[i]),
         .dir    (dir_q[i]),
         .drv    (drv_q[i]),
         .data   (data_q[i]),
         .addr   (addr_bits[i]),
         .ext_oe (ext_oe[i]),
         .oe     (pin_oe[i]),
         .out    (pin_out[i]),
         .fast   (pin_fast[i]),
         .od     (od_vec[i])
      );
   end

   AST_EXT_OE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_oe & ACT_MASK & ~od_vec & ~pin_oe) == '0) else $error("ext oe ignored"); // R5
   AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe | pin_out | pin_fast) & ~ACT_MASK) == '0) else $error("inactive pin driven"); // R9
   AST_FAST_NOT_OD: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_fast & od_vec) == '0) else $error("fast on open-drain pin"); // R7
   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && pin_fast == '0)) else $error("not idle after reset"); // R1
endmodule

// File: tb/gpio_cfg_port_tb.sv
module gpio_cfg_port_tb_top;
   localparam int   CLK_PERIOD = 10;
   localparam logic [7:0] SLEW_A = 8'hF0;
   localparam logic [7:0] SLEW_B = 8'h02;
   localparam logic [7:0] ACT_B  = 8'h03;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, addr_bits = '0, ext_oe = '0, pin_in = '0;
   logic [7:0] rd_a, oe_a, out_a, fast_a, rd_b, oe_b, out_b, fast_b;
   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_cfg_port #(.PIN_W(8), .ACTIVE_PINS(8), .ADDR_CAPABLE(1'b1), .SLEW_MASK(SLEW_A)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_a), .addr_bits(addr_bits), .ext_oe(ext_oe),
      .pin_in(pin_in), .pin_oe(oe_a), .pin_out(out_a), .pin_fast(fast_a));

   gpio_cfg_port #(.PIN_W(8), .ACTIVE_PINS(2), .ADDR_CAPABLE(1'b0), .SLEW_MASK(SLEW_B)) dut_n (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_b), .addr_bits(addr_bits), .ext_oe(ext_oe),
      .pin_in(pin_in), .pin_oe(oe_b), .pin_out(out_b), .pin_fast(fast_b));

   logic [7:0] m_mode, m_dir, m_drv, m_data;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      case (a)
         3'd0: m_mode = d;
         3'd1: m_dir  = d;
         3'd2: m_drv  = d;
         3'd3: m_data = d;
         default: ;
      endcase
   endtask

   task automatic rd_both(input logic [2:0] a, output logic [7:0] va, output logic [7:0] vb);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      va = rd_a; vb = rd_b;
      bus_sel = 1'b0;
   endtask

   // expected outputs of the full port from R4..R7
   task automatic chk_pins(input string req);
      logic [7:0] val, en, od, e_oe, e_out, e_fast;
      #1;
      val    = (m_mode & addr_bits) | (~m_mode & m_data);
      en     = m_dir | ext_oe;
      od     = m_drv & ~SLEW_A;
      e_oe   = (en & ~od) | (en & od & ~val);
      e_out  = val & ~od;
      e_fast = m_drv & SLEW_A;
      chk({req, " pin_oe"},   oe_a,   e_oe);
      chk({req, " pin_out"},  out_a,  e_out);
      chk({req, " pin_fast"}, fast_a, e_fast);
   endtask

   initial begin
      logic [7:0] va, vb;
      m_mode = 0; m_dir = 0; m_drv = 0; m_data = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd_both(3'(a), va, vb);
         chk("R1 reg", va, 8'h00);
      end
      chk("R1 pin_oe", oe_a, 8'h00);
      chk("R1 pin_fast", fast_a, 8'h00);

      // R2, R5: direction sweep with external enables
      wr(3'd3, 8'hA5);
      for (int v = 0; v < 256; v++) begin
         wr(3'd1, 8'(v));
         ext_oe = 8'((v * 37) & 255);
         rd_both(3'd1, va, vb);
         chk("R2 dir readback", va, 8'(v));
         chk_pins("R5");
      end

      // R4: mode mux sweep
      wr(3'd1, 8'hFF); ext_oe = 8'h00;
      for (int v = 0; v < 256; v++) begin
         wr(3'd0, 8'(v));
         wr(3'd3, 8'((v * 3) & 255));
         addr_bits = ~8'(v) ^ 8'h69;
         rd_both(3'd0, va, vb);
         chk("R2 mode readback", va, 8'(v));
         rd_both(3'd3, va, vb);
         chk("R2 data readback", va, 8'((v * 3) & 255));
         chk_pins("R4");
      end

      // R6, R7: drive sweep
      wr(3'd0, 8'h00);
      for (int v = 0; v < 256; v++) begin
         wr(3'd2, 8'(v));
         wr(3'd3, 8'(v) ^ 8'h3C);
         wr(3'd1, 8'(v) ^ 8'hC3);
         ext_oe = 8'(v) ^ 8'h5A;
         rd_both(3'd2, va, vb);
         chk("R2 drv readback", va, 8'(v));
         chk_pins("R6 R7");
      end

      // R3: unimplemented offsets
      for (int a = 5; a < 8; a++) begin
         rd_both(3'(a), va, vb);
         chk("R3 unimpl", va, 8'h00);
      end

      // R8: pin input synchronizer latency
      for (int k = 0; k < 6; k++) begin
         logic [7:0] prev, pat;
         @(negedge clk);
         rd_both(3'd4, prev, vb);
         pat = 8'((k * 91 + 17) & 255);
         pin_in = pat;
         @(negedge clk);
         rd_both(3'd4, va, vb);
         chk("R8 one edge", va, prev);
         @(negedge clk);
         rd_both(3'd4, va, vb);
         chk("R8 two edges", va, pat);
         chk("R9 narrow pins", vb, pat & ACT_B);
      end

      // R3, R9: narrow variant with no mode register
      wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      addr_bits = 8'h00; ext_oe = 8'hFF;
      rd_both(3'd0, va, vb); chk("R3 no mode reg", vb, 8'h00);
      rd_both(3'd1, va, vb); chk("R9 dir bits", vb, ACT_B);
      rd_both(3'd2, va, vb); chk("R9 drv bits", vb, ACT_B);
      rd_both(3'd3, va, vb); chk("R9 data bits", vb, ACT_B);
      #1;
      // pin0 open-drain value 1 -> released; pin1 slew-capable push-pull value 1 (data, mode absent)
      chk("R9 narrow oe", oe_b, 8'h02);
      chk("R3 narrow out uses data", out_b, 8'h02);
      chk("R9 narrow fast", fast_b, 8'h02);
      wr(3'd3, 8'h00);
      #1;
      chk("R6 narrow od low", oe_b, 8'h03);
      chk("R6 narrow out", out_b, 8'h00);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule